// File: doc/BRIEF.md
# Grayscale Shift and Latch Data Path

This block is the serial data path of a multi-channel constant-current driver. Grayscale words arrive one bit at a time on a serial input, and each rising edge of a shift clock pin moves them into a wide common shift register. A rising edge on a latch pin copies the whole register into a grayscale latch. The latch drives parallel red and blue grayscale buses that a separate PWM stage consumes. In the step right after that copy, a configuration word held outside the block is written into the low end of the shift register. The next serial transfer then pushes that word out of the serial output as readback.

The register is built from slots of `SLOT_W` bits. The slots are grouped in threes from bit 0 upward: red channel, reserved, blue channel. `GROUPS` such groups make up the word, and with the defaults (12-bit slots, 8 groups) it is 288 bits wide. The configuration word is `CFG_W` bits wide, 205 by default, and must not be wider than the register.

The shift clock, the latch and the serial data pins are sampled in the system clock domain through a synchroniser `SYNC_STAGES` deep, and rising edges are detected after that. A controller state machine orders the work. It has three states:
- `GSL_IDLE` performs a shift on a shift-clock edge. On a latch edge it moves to `GSL_XFER`.
- `GSL_XFER` loads the grayscale latch and always moves on to `GSL_RELOAD`.
- `GSL_RELOAD` writes the configuration word into the shift register and returns to `GSL_IDLE`.

Edges that arrive while the controller is in `GSL_XFER` or `GSL_RELOAD` are not acted on. Shift and latch edges therefore need to be spaced at least three system clocks apart.

Top module: `gs_shift_latch`

## Requirements
- R1: While `rst_n` is low, the shift register and the grayscale latch are all zeros. As a result `sdo`, `red_gs` and `blue_gs` read zero.
- R2: Each rising edge of `sclk` shifts the register one place toward its MSB and takes the current `sdi` level into bit 0. A word is therefore loaded MSB first.
- R3: `sdo` always shows the register's top bit, bit `SR_W-1`.
- R4: A rising edge of `latch` copies every register bit into the grayscale latch, reserved slots included. The new values reach `red_gs`/`blue_gs` with no further stage.
- R5: In the cycle after the copy, register bits `CFG_W-1:0` take `cfg_word` and the bits above keep their values. Shifting the register out then returns the configuration word on `sdo`, MSB first, after the upper bits.
- R6: Slot k occupies register bits `k*SLOT_W +: SLOT_W`. For group g, `red_gs[g*SLOT_W +: SLOT_W]` carries slot 3g and `blue_gs[g*SLOT_W +: SLOT_W]` carries slot 3g+2. Slot 3g+1 is reserved and reaches no output.
- R7: Without a latch rising edge the grayscale outputs hold their values, whatever is shifted in meanwhile. With no edge at all, the shift register holds too.
- R8: When a shift edge and a latch edge are detected in the same cycle, the latch wins. The register is copied unshifted and that shift is dropped.
- R9: Falling edges of `sclk` and `latch` change neither the register nor the grayscale outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data in |
| sclk | input | 1 | Shift clock pin, rising edge active |
| latch | input | 1 | Latch strobe pin, rising edge active |
| cfg_word | input | CFG_W | Configuration word reloaded after each latch |
| sdo | output | 1 | Serial data out (register MSB) |
| red_gs | output | GROUPS*SLOT_W | Latched red channel grayscale values, group 0 lowest |
| blue_gs | output | GROUPS*SLOT_W | Latched blue channel grayscale values, group 0 lowest |

## Verification
The bench builds the block with 4-bit slots, two groups and a 7-bit configuration word, which gives a 24-bit register. With that size, all 128 configuration values can be reloaded. Every bit of every transfer, including the reserved slots and the configuration readback, is followed on `sdo` against a bench model. The small word also leaves room for shifting a fresh pattern in on each pass, while the previous reload is read back out. Coincident shift and latch edges are covered as a separate case.

// File: rtl/gsl_pkg.sv
package gsl_pkg;

    typedef enum logic [1:0] {
        GSL_IDLE   = 2'd0,
        GSL_XFER   = 2'd1,
        GSL_RELOAD = 2'd2
    } gsl_state_e;

    typedef enum logic [1:0] {
        SR_HOLD     = 2'd0,
        SR_SHIFT    = 2'd1,
        SR_LOAD_CFG = 2'd2
    } sr_op_e;

    localparam int unsigned SLOTS_PER_GROUP = 3;
    localparam int unsigned RED_OFS         = 0;
    localparam int unsigned BLUE_OFS        = 2;

    function automatic int unsigned slot_lsb(input int unsigned grp,
                                             input int unsigned ofs,
                                             input int unsigned width);
        return (grp * SLOTS_PER_GROUP + ofs) * width;
    endfunction

endpackage

// File: rtl/gsl_pin_sync.sv
module gsl_pin_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned N      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o
);
    logic [STAGES-1:0][N-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign lvl_o = chain_q[STAGES-1];

endmodule

// File: rtl/gsl_rise_detect.sv
module gsl_rise_detect #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

    // R2
    rise_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/gsl_ctrl.sv
module gsl_ctrl
    import gsl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   shift_rise,
    input  logic   latch_rise,
    output sr_op_e sr_op,
    output logic   gs_load
);
    gsl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GSL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GSL_IDLE:   if (latch_rise) state_d = GSL_XFER;
            GSL_XFER:   state_d = GSL_RELOAD;
            GSL_RELOAD: state_d = GSL_IDLE;
            default:    state_d = GSL_IDLE;
        endcase
    end

    always_comb begin
        sr_op   = SR_HOLD;
        gs_load = 1'b0;
        unique case (state_q)
            GSL_IDLE:   if (shift_rise && !latch_rise) sr_op = SR_SHIFT;
            GSL_XFER:   gs_load = 1'b1;
            GSL_RELOAD: sr_op = SR_LOAD_CFG;
            default:    sr_op = SR_HOLD;
        endcase
    end

    // R5
    xfer_then_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GSL_XFER) |=> (state_q == GSL_RELOAD));

    // R8
    latch_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GSL_IDLE && latch_rise) |-> (sr_op == SR_HOLD));

    // R4
    latch_starts_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GSL_IDLE && latch_rise) |=> gs_load);

endmodule

// File: rtl/gsl_shift_path.sv
module gsl_shift_path
    import gsl_pkg::*;
#(
    parameter int unsigned SR_W  = 288,
    parameter int unsigned CFG_W = 205
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sr_op_e            op,
    input  logic              sdi,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic [SR_W-1:0]   sr_o,
    output logic              sdo
);
    logic [SR_W-1:0] sr_q, sr_d, cfg_pad;

    assign cfg_pad = SR_W'(cfg_word);

    always_comb begin
        sr_d = sr_q;
        unique case (op)
            SR_SHIFT:    sr_d = {sr_q[SR_W-2:0], sdi};
            SR_LOAD_CFG: begin
                for (int i = 0; i < SR_W; i++) begin
                    if (i < CFG_W) sr_d[i] = cfg_pad[i];
                end
            end
            default:     sr_d = sr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign sr_o = sr_q;
    assign sdo  = sr_q[SR_W-1];

    // R2
    shift_moves_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SR_SHIFT) |=> (sdo == $past(sr_q[SR_W-2])));

    // R5
    reload_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SR_LOAD_CFG) |=> (sr_q[CFG_W-1:0] == $past(cfg_word)));

    // R5
    reload_top_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SR_LOAD_CFG) |=> $stable(sdo));

    // R7
    sr_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SR_HOLD) |=> $stable(sr_q));

endmodule

// File: rtl/gsl_gs_latch.sv
module gsl_gs_latch #(
    parameter int unsigned W = 288
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    // R4
    gs_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R7
    gs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/gsl_channel_map.sv
module gsl_channel_map
    import gsl_pkg::*;
#(
    parameter int unsigned SLOT_W = 12,
    parameter int unsigned GROUPS = 8
) (
    input  logic [GROUPS*SLOTS_PER_GROUP*SLOT_W-1:0] gs_i,
    output logic [GROUPS*SLOT_W-1:0]                 red_o,
    output logic [GROUPS*SLOT_W-1:0]                 blue_o
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        localparam int unsigned RED_LSB  = slot_lsb(g, RED_OFS,  SLOT_W);
        localparam int unsigned BLUE_LSB = slot_lsb(g, BLUE_OFS, SLOT_W);
        assign red_o [g*SLOT_W +: SLOT_W] = gs_i[RED_LSB  +: SLOT_W];
        assign blue_o[g*SLOT_W +: SLOT_W] = gs_i[BLUE_LSB +: SLOT_W];
    end

endmodule

// File: rtl/gs_shift_latch.sv
module gs_shift_latch
    import gsl_pkg::*;
#(
    parameter int unsigned SLOT_W      = 12,
    parameter int unsigned GROUPS      = 8,
    parameter int unsigned CFG_W       = 205,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sdi,
    input  logic                       sclk,
    input  logic                       latch,
    input  logic [CFG_W-1:0]           cfg_word,
    output logic                       sdo,
    output logic [GROUPS*SLOT_W-1:0]   red_gs,
    output logic [GROUPS*SLOT_W-1:0]   blue_gs
);
    localparam int unsigned SR_W = GROUPS * SLOTS_PER_GROUP * SLOT_W;

    logic [2:0]      pin_lvl;
    logic [1:0]      strobe_rise;
    sr_op_e          sr_op;
    logic            gs_load;
    logic [SR_W-1:0] sr_word;
    logic [SR_W-1:0] gs_word;

    gsl_pin_sync #(.STAGES(SYNC_STAGES), .N(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({latch, sclk, sdi}),
        .lvl_o (pin_lvl)
    );

    gsl_rise_detect #(.N(2)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pin_lvl[2:1]),
        .rise_o (strobe_rise)
    );

    gsl_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_rise (strobe_rise[0]),
        .latch_rise (strobe_rise[1]),
        .sr_op      (sr_op),
        .gs_load    (gs_load)
    );

    gsl_shift_path #(.SR_W(SR_W), .CFG_W(CFG_W)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (sr_op),
        .sdi      (pin_lvl[0]),
        .cfg_word (cfg_word),
        .sr_o     (sr_word),
        .sdo      (sdo)
    );

    gsl_gs_latch #(.W(SR_W)) u_gs (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gs_load),
        .d     (sr_word),
        .q     (gs_word)
    );

    gsl_channel_map #(.SLOT_W(SLOT_W), .GROUPS(GROUPS)) u_map (
        .gs_i   (gs_word),
        .red_o  (red_gs),
        .blue_o (blue_gs)
    );

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |-> (sdo == 1'b0 && red_gs == '0 && blue_gs == '0));

    // R9
    fall_no_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_rise == 2'b00 && sr_op == SR_HOLD && !gs_load) |=>
            ($stable(red_gs) && $stable(blue_gs) && $stable(sdo)));

endmodule

// File: tb/gs_shift_latch_tb_top.sv
`timescale 1ns/1ps
module gs_shift_latch_tb_top;
    localparam int unsigned SLOT_W = 4;
    localparam int unsigned GROUPS = 2;
    localparam int unsigned CFG_W  = 7;
    localparam int unsigned SR_W   = GROUPS * 3 * SLOT_W;
    localparam int unsigned CH_W   = GROUPS * SLOT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdi = 1'b0, sclk = 1'b0, latch = 1'b0;
    logic [CFG_W-1:0] cfg_word = '0;
    logic sdo;
    logic [CH_W-1:0] red_gs, blue_gs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [SR_W-1:0] m_sr = '0;
    logic [SR_W-1:0] m_gs = '0;

    always #2 clk = ~clk;

    gs_shift_latch #(.SLOT_W(SLOT_W), .GROUPS(GROUPS), .CFG_W(CFG_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .sclk(sclk), .latch(latch),
        .cfg_word(cfg_word), .sdo(sdo), .red_gs(red_gs), .blue_gs(blue_gs)
    );

    function automatic logic [CH_W-1:0] pick(input logic [SR_W-1:0] g, input int ofs);
        logic [CH_W-1:0] r;
        for (int k = 0; k < GROUPS; k++) r[k*SLOT_W +: SLOT_W] = g[(3*k + ofs)*SLOT_W +: SLOT_W];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_outputs(input string req);
        chk({req, " red"},  32'(red_gs),  32'(pick(m_gs, 0)));
        chk({req, " blue"}, 32'(blue_gs), 32'(pick(m_gs, 2)));
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk) sdi = b;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        m_sr = {m_sr[SR_W-2:0], b};
        chk("R2/R3 sdo after shift", 32'(sdo), 32'(m_sr[SR_W-1]));
        chk_outputs("R7 hold while shifting");
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 sclk fall sdo", 32'(sdo), 32'(m_sr[SR_W-1]));
    endtask

    task automatic latch_pulse(input logic [CFG_W-1:0] cfg);
        @(negedge clk) cfg_word = cfg;
        latch = 1'b1;
        repeat (6) @(negedge clk);
        m_gs = m_sr;
        m_sr[CFG_W-1:0] = cfg;
        chk_outputs("R4/R6 latched");
        chk("R5 sdo after reload", 32'(sdo), 32'(m_sr[SR_W-1]));
        latch = 1'b0;
        repeat (4) @(negedge clk);
        chk_outputs("R9 latch fall");
        chk("R9 latch fall sdo", 32'(sdo), 32'(m_sr[SR_W-1]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 sdo", 32'(sdo), 32'd0);
        chk("R1 red", 32'(red_gs), 32'd0);
        chk("R1 blue", 32'(blue_gs), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Sweep every configuration value; each pass also reads back the previous reload.
        for (int it = 0; it < 128; it++) begin
            logic [31:0] h;
            logic [SR_W-1:0] word;
            h = (32'(it) + 32'd1) * 32'h9E37_79B9 ^ 32'h5A5A_A5A5;
            word = (it == 1) ? '1 : (it == 2) ? '0 : SR_W'(h);
            for (int b = SR_W - 1; b >= 0; b--) shift_bit(word[b]);
            latch_pulse(CFG_W'(it));
        end

        // R8 coincident shift and latch edges: latch wins, shift dropped
        @(negedge clk) sdi = ~m_sr[0];
        cfg_word = 7'h55;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        latch = 1'b1;
        repeat (6) @(negedge clk);
        m_gs = m_sr;
        m_sr[CFG_W-1:0] = 7'h55;
        chk_outputs("R8 coincident");
        chk("R8 coincident sdo", 32'(sdo), 32'(m_sr[SR_W-1]));
        sclk = 1'b0;
        latch = 1'b0;
        repeat (4) @(negedge clk);

        // R5 final readback of the last reload
        for (int b = 0; b < SR_W; b++) shift_bit(1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule